// File: doc/BRIEF.md
# Boundary-Scan Data Register Bank

This block sits behind a test access port controller and holds the data registers that the serial test path can reach. The controller supplies the test clock, the decoded controller states and two resets. The block keeps a 3-bit instruction register, decodes the active instruction, and places one of four data registers between the serial input and the serial output. The four registers are a one-bit bypass stage, a 38-cell boundary chain, a fixed 32-bit identification word and a private 8-bit mode register.

The boundary chain captures the parallel pin inputs and holds an update latch for each cell. The latches drive the pins only while the external-test instruction is active. At all other times the pins carry the functional core values. The mode register can be shifted and updated but never captures anything. Only power-on reset clears its latched value. The serial output is retimed on the falling test clock edge, and a separate enable flags when it carries valid data.

Top module: `jtb_bank`

## Requirements
- R1: The active instruction selects the serial path as follows. Code 3'b000 (external test) and code 3'b001 (sample/preload) select the boundary chain. Code 3'b010 selects the identification register. Code 3'b011 selects the mode register. Every code from 3'b100 to 3'b111 selects the bypass stage.
- R2: After power-on reset or TAP reset, the active instruction is 3'b010, so the identification register is in the serial path.
- R3: In bypass, capture loads 0 into the single stage, and each shift passes `tdi` to `tdo` with a delay of exactly one stage.
- R4: Capture with the identification register selected loads 32'h13A5_10D9, and shifting sends it out LSB first. The fields are: version 1 in bits 31:28, part number 16'h3A51 in bits 27:12, zeros in bits 11:8, manufacturer code 7'h6C in bits 7:1, and a constant 1 in bit 0.
- R5: The boundary chain has exactly 38 cells. Capture loads `pin_in[k]` into cell k. Cell 0 is nearest `tdo`, and `tdi` enters cell 37, so an input bit appears at `tdo` 38 shifts later.
- R6: Update-DR under code 000 or 001 copies the boundary shift stages into the update latches. `pin_out` equals the latches while code 000 is active and equals `core_in` under every other code.
- R7: Under code 3'b011 the mode register shifts and updates, and `mode_out` shows the update latch. A capture leaves the mode shift stage unchanged.
- R8: Only `por` clears `mode_out`. A `tap_rst` leaves it unchanged.
- R9: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 after a falling edge at which `shift_dr` or `shift_ir` was high, and 0 otherwise.
- R10: Capture-IR loads 3'b001 into the instruction shift stage. Shift-IR moves it out LSB first, and Update-IR makes the shifted code active.
- R11: Update-DR under an instruction that does not select a register leaves that register's latch unchanged. This covers the boundary latches outside codes 000/001 and `mode_out` outside code 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| tap_rst | input | 1 | TAP reset (Test-Logic-Reset state), synchronous, active high |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | Controller in Capture-IR |
| shift_ir | input | 1 | Controller in Shift-IR |
| update_ir | input | 1 | Controller in Update-IR |
| capture_dr | input | 1 | Controller in Capture-DR |
| shift_dr | input | 1 | Controller in Shift-DR |
| update_dr | input | 1 | Controller in Update-DR |
| pin_in | input | 38 | Pin-side values captured by the boundary chain |
| core_in | input | 38 | Functional values for the pins outside external test |
| pin_out | output | 38 | Values presented to the pins |
| mode_out | output | 8 | Mode register update latch |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | High while `tdo` carries valid shift data |

## Verification
The bench drives the decoded controller states in the order a real controller would produce them. One loop walks every instruction code and checks the first shifted-out byte. A wrong decode of the 100–111 range, or a bypass stage that captures 1, shows up as a shifted or inverted byte. Bench tests shift the boundary chain 46 times to prove its length: a chain one cell off moves the echoed input bits. They also check that the mode register returns its old contents after a capture, and that `mode_out` survives a TAP reset but not a power-on reset. A design that cleared the mode latch on either reset, or that let an update under the wrong instruction reach a latch, would fail these checks.

// File: rtl/jtb_pkg.sv
package jtb_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] IR_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] IR_SAMPLE  = 3'b001;
    localparam logic [IR_W-1:0] IR_IDCODE  = 3'b010;
    localparam logic [IR_W-1:0] IR_MODE    = 3'b011;
    localparam logic [IR_W-1:0] IR_CAPT    = 3'b001;

    typedef enum logic [1:0] {
        PATH_BSR  = 2'd0,
        PATH_ID   = 2'd1,
        PATH_MODE = 2'd2,
        PATH_BYP  = 2'd3
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     drive_pins;
    } ir_dec_t;

    function automatic ir_dec_t decode_ir(input logic [IR_W-1:0] code);
        ir_dec_t d;
        d.drive_pins = 1'b0;
        d.path       = PATH_BYP;
        if (!code[2]) begin
            case (code[1:0])
                2'b00: begin
                    d.path       = PATH_BSR;
                    d.drive_pins = 1'b1;
                end
                2'b01:   d.path = PATH_BSR;
                2'b10:   d.path = PATH_ID;
                default: d.path = PATH_MODE;
            endcase
        end
        return d;
    endfunction

    function automatic logic [ID_W-1:0] build_id(input logic [3:0]  ver,
                                                 input logic [15:0] part,
                                                 input logic [6:0]  mfr);
        return {ver, part, 4'b0000, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/jtb_ir.sv
module jtb_ir
    import jtb_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  logic            capture_ir,
    input  logic            shift_ir,
    input  logic            update_ir,
    output logic [IR_W-1:0] ir_q,
    output logic            ser_out
);

    logic [IR_W-1:0] stage;

    always_ff @(posedge tck) begin
        if (rst) begin
            stage <= '0;
        end else if (capture_ir) begin
            stage <= IR_CAPT;
        end else if (shift_ir) begin
            stage <= {tdi, stage[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_q <= IR_IDCODE;
        end else if (update_ir) begin
            ir_q <= stage;
        end
    end

    assign ser_out = stage[0];

endmodule

// File: rtl/jtb_bsr.sv
module jtb_bsr #(
    parameter int LEN = 38
) (
    input  logic           tck,
    input  logic           rst,
    input  logic           tdi,
    input  logic           sel,
    input  logic           capture,
    input  logic           shift,
    input  logic           update,
    input  logic [LEN-1:0] pin_in,
    output logic [LEN-1:0] upd_q,
    output logic           ser_out
);

    logic [LEN-1:0] sh;

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        logic from_up;
        if (k == LEN - 1) begin : g_head
            assign from_up = tdi;
        end else begin : g_body
            assign from_up = sh[k+1];
        end

        always_ff @(posedge tck) begin
            if (rst) begin
                sh[k] <= 1'b0;
            end else if (sel && capture) begin
                sh[k] <= pin_in[k];
            end else if (sel && shift) begin
                sh[k] <= from_up;
            end
        end

        always_ff @(posedge tck) begin
            if (rst) begin
                upd_q[k] <= 1'b0;
            end else if (sel && update) begin
                upd_q[k] <= sh[k];
            end
        end
    end

    assign ser_out = sh[0];

endmodule

// File: rtl/jtb_mode.sv
module jtb_mode #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         por,
    input  logic         tdi,
    input  logic         sel,
    input  logic         shift,
    input  logic         update,
    output logic [W-1:0] mode_q,
    output logic         ser_out
);

    logic [W-1:0] sh;

    always_ff @(posedge tck) begin
        if (por) begin
            sh <= '0;
        end else if (sel && shift) begin
            sh <= {tdi, sh[W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (por) begin
            mode_q <= '0;
        end else if (sel && update) begin
            mode_q <= sh;
        end
    end

    assign ser_out = sh[0];

endmodule

// File: rtl/jtb_bank.sv
module jtb_bank
    import jtb_pkg::*;
#(
    parameter int          BSR_LEN    = 38,
    parameter int          MODE_W     = 8,
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h3A51,
    parameter logic [6:0]  MFR_CODE   = 7'h6C
) (
    input  logic               tck,
    input  logic               por,
    input  logic               tap_rst,
    input  logic               tdi,
    input  logic               capture_ir,
    input  logic               shift_ir,
    input  logic               update_ir,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic [BSR_LEN-1:0] pin_in,
    input  logic [BSR_LEN-1:0] core_in,
    output logic [BSR_LEN-1:0] pin_out,
    output logic [MODE_W-1:0]  mode_out,
    output logic               tdo,
    output logic               tdo_en
);

    localparam logic [ID_W-1:0] ID_VALUE = build_id(ID_VERSION, ID_PART, MFR_CODE);

    logic              rst_tap;
    logic [IR_W-1:0]   ir_q;
    logic              ir_so;
    ir_dec_t           dec;
    logic              sel_bsr, sel_id, sel_mode, sel_byp;
    logic [ID_W-1:0]   id_sr;
    logic              byp_q;
    logic [BSR_LEN-1:0] bsr_upd;
    logic              bsr_so;
    logic              mode_so;
    logic              dr_so;

    assign rst_tap = por | tap_rst;

    jtb_ir u_ir (
        .tck        (tck),
        .rst        (rst_tap),
        .tdi        (tdi),
        .capture_ir (capture_ir),
        .shift_ir   (shift_ir),
        .update_ir  (update_ir),
        .ir_q       (ir_q),
        .ser_out    (ir_so)
    );

    assign dec      = decode_ir(ir_q);
    assign sel_bsr  = (dec.path == PATH_BSR);
    assign sel_id   = (dec.path == PATH_ID);
    assign sel_mode = (dec.path == PATH_MODE);
    assign sel_byp  = (dec.path == PATH_BYP);

    always_ff @(posedge tck) begin
        if (rst_tap) begin
            id_sr <= ID_VALUE;
        end else if (sel_id && capture_dr) begin
            id_sr <= ID_VALUE;
        end else if (sel_id && shift_dr) begin
            id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (rst_tap) begin
            byp_q <= 1'b0;
        end else if (sel_byp && capture_dr) begin
            byp_q <= 1'b0;
        end else if (sel_byp && shift_dr) begin
            byp_q <= tdi;
        end
    end

    jtb_bsr #(.LEN(BSR_LEN)) u_bsr (
        .tck     (tck),
        .rst     (rst_tap),
        .tdi     (tdi),
        .sel     (sel_bsr),
        .capture (capture_dr),
        .shift   (shift_dr),
        .update  (update_dr),
        .pin_in  (pin_in),
        .upd_q   (bsr_upd),
        .ser_out (bsr_so)
    );

    jtb_mode #(.W(MODE_W)) u_mode (
        .tck     (tck),
        .por     (por),
        .tdi     (tdi),
        .sel     (sel_mode),
        .shift   (shift_dr),
        .update  (update_dr),
        .mode_q  (mode_out),
        .ser_out (mode_so)
    );

    always_comb begin
        case (dec.path)
            PATH_BSR:  dr_so = bsr_so;
            PATH_ID:   dr_so = id_sr[0];
            PATH_MODE: dr_so = mode_so;
            default:   dr_so = byp_q;
        endcase
    end

    always_ff @(negedge tck) begin
        if (rst_tap) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= shift_ir ? ir_so : dr_so;
            tdo_en <= shift_ir | shift_dr;
        end
    end

    assign pin_out = dec.drive_pins ? bsr_upd : core_in;

endmodule

// File: rtl/jtb_bank_chk.sv
module jtb_bank_chk #(
    parameter int BSR_LEN = 38,
    parameter int MODE_W  = 8
) (
    input logic               tck,
    input logic               por,
    input logic               tap_rst,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               shift_ir,
    input logic               update_dr,
    input logic               update_ir,
    input logic [2:0]         ir_q,
    input logic               byp_q,
    input logic [BSR_LEN-1:0] bsr_upd,
    input logic [MODE_W-1:0]  mode_out,
    input logic               tdo_en
);

    // R2: TAP reset returns the identification instruction
    a_r2_reset_to_id: assert property (@(posedge tck) disable iff (por)
        tap_rst |=> (ir_q == 3'b010));

    // R3: bypass stage captures zero
    a_r3_byp_capture: assert property (@(posedge tck) disable iff (por || tap_rst)
        (capture_dr && ir_q[2]) |=> (byp_q == 1'b0));

    // R8: TAP reset leaves the mode latch alone
    a_r8_mode_keeps: assert property (@(posedge tck) disable iff (por)
        tap_rst |=> $stable(mode_out));

    // R11: mode latch changes only on update under code 011
    a_r11_mode_hold: assert property (@(posedge tck) disable iff (por)
        (!update_dr || ir_q != 3'b011) |=> $stable(mode_out));

    // R6 / R11: boundary latches change only on update under 000/001
    a_r6_bsr_hold: assert property (@(posedge tck) disable iff (por || tap_rst)
        (!update_dr || ir_q[2:1] != 2'b00) |=> $stable(bsr_upd));

    // R10: active instruction changes only on Update-IR
    a_r10_ir_hold: assert property (@(posedge tck) disable iff (por || tap_rst)
        !update_ir |=> $stable(ir_q));

    // R9: output enable follows the shift states at the falling edge
    a_r9_en_on: assert property (@(negedge tck) disable iff (por || tap_rst)
        (shift_dr || shift_ir) |=> tdo_en);

    a_r9_en_off: assert property (@(negedge tck) disable iff (por || tap_rst)
        !(shift_dr || shift_ir) |=> !tdo_en);

endmodule

bind jtb_bank jtb_bank_chk #(.BSR_LEN(BSR_LEN), .MODE_W(MODE_W)) u_chk (
    .tck        (tck),
    .por        (por),
    .tap_rst    (tap_rst),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .shift_ir   (shift_ir),
    .update_dr  (update_dr),
    .update_ir  (update_ir),
    .ir_q       (ir_q),
    .byp_q      (byp_q),
    .bsr_upd    (bsr_upd),
    .mode_out   (mode_out),
    .tdo_en     (tdo_en)
);

// File: tb/jtb_bank_bench.sv
`timescale 1ns/1ps
module jtb_bank_bench;

    localparam int          N       = 38;
    localparam logic [31:0] ID_EXP  = 32'h13A5_10D9;
    localparam logic [N-1:0] PIN    = 38'h2A_5C3E_91B7;
    localparam logic [N-1:0] CORE   = 38'h15_0F0F_3C3C;
    localparam logic [N-1:0] BPAT   = 38'h31_A6C2_4E8D;
    localparam logic [7:0]  TDI_PAT = 8'hC5;

    // {instruction code, expected first byte out after capture}
    localparam logic [10:0] VEC [8] = '{
        {3'b000, 8'hB7}, {3'b001, 8'hB7}, {3'b010, 8'hD9}, {3'b011, 8'h5A},
        {3'b100, 8'h8A}, {3'b101, 8'h8A}, {3'b110, 8'h8A}, {3'b111, 8'h8A}
    };

    logic tck = 1'b0;
    logic por = 1'b1, tap_rst = 1'b0, tdi = 1'b0;
    logic capture_ir = 0, shift_ir = 0, update_ir = 0;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic [N-1:0] pin_in = PIN, core_in = CORE, pin_out;
    logic [7:0]   mode_out;
    logic         tdo, tdo_en;

    int n_chk = 0;
    int n_fail = 0;

    always #5 tck = ~tck;

    jtb_bank u_jtb_bank (
        .tck(tck), .por(por), .tap_rst(tap_rst), .tdi(tdi),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .pin_in(pin_in), .core_in(core_in), .pin_out(pin_out),
        .mode_out(mode_out), .tdo(tdo), .tdo_en(tdo_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic cyc(input logic t, output logic o, output logic oe);
        tdi = t;
        @(negedge tck);
        #1;
        o  = tdo;
        oe = tdo_en;
        tick();
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o, oe;
        capture_ir = 1; tick(); capture_ir = 0;
        shift_ir = 1;
        for (int i = 0; i < 3; i++) begin
            cyc(code[i], o, oe);
            cap[i] = o;
        end
        shift_ir = 0;
        update_ir = 1; tick(); update_ir = 0;
    endtask

    task automatic dr_capture();
        capture_dr = 1; tick(); capture_dr = 0;
    endtask

    task automatic dr_update();
        update_dr = 1; tick(); update_dr = 0;
    endtask

    task automatic dr_shift(input int n, input logic [63:0] pat,
                            output logic [63:0] outv, output logic oe_all);
        logic o, oe;
        outv = '0;
        oe_all = 1'b1;
        shift_dr = 1;
        for (int i = 0; i < n; i++) begin
            cyc(pat[i], o, oe);
            outv[i] = o;
            oe_all &= oe;
        end
        shift_dr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] ov;
        logic        oeall;
        logic [2:0]  cap;

        repeat (3) tick();
        por = 0;
        tick();

        // reset state
        chk("R9 tdo_en low after reset", {63'b0, tdo_en}, 64'd0);
        chk("R8 mode_out cleared by por", {56'b0, mode_out}, 64'd0);
        chk("R6 pins follow core after reset", {26'b0, pin_out}, {26'b0, CORE});

        // R2 / R4: identification register selected by default
        dr_capture();
        dr_shift(32, 64'd0, ov, oeall);
        chk("R2 R4 default path id word", ov, {32'b0, ID_EXP});
        chk("R9 tdo_en high during shift", {63'b0, oeall}, 64'd1);
        @(negedge tck); #1;
        chk("R9 tdo_en low after shift", {63'b0, tdo_en}, 64'd0);
        tick();

        // R10: instruction capture pattern and R7 mode preload
        load_ir(3'b011, cap);
        chk("R10 ir capture shifted out", {61'b0, cap}, 64'd1);
        dr_shift(8, 64'h5A, ov, oeall);
        dr_update();
        chk("R7 mode update", {56'b0, mode_out}, 64'h5A);

        // R1 R3 R4 R5 R7: table walk across every instruction code
        for (int i = 0; i < 8; i++) begin
            load_ir(VEC[i][10:8], cap);
            dr_capture();
            dr_shift(8, {56'b0, TDI_PAT}, ov, oeall);
            chk($sformatf("R1 code %0d first byte (R3 R4 R5 R7)", VEC[i][10:8]),
                ov, {56'b0, VEC[i][7:0]});
        end

        // R5: chain length via sample/preload
        load_ir(3'b001, cap);
        dr_capture();
        dr_shift(46, {56'b0, TDI_PAT}, ov, oeall);
        chk("R5 captured pins", {26'b0, ov[37:0]}, {26'b0, PIN});
        chk("R5 tdi echo after 38 shifts", {56'b0, ov[45:38]}, {56'b0, TDI_PAT});

        // R6: preload, then external test drives pins
        dr_shift(38, {26'b0, BPAT}, ov, oeall);
        dr_update();
        chk("R6 sample keeps core on pins", {26'b0, pin_out}, {26'b0, CORE});
        load_ir(3'b000, cap);
        chk("R6 extest drives latches", {26'b0, pin_out}, {26'b0, BPAT});

        // R11: update under id leaves latches
        load_ir(3'b011, cap);
        dr_shift(8, 64'hFF, ov, oeall);
        load_ir(3'b010, cap);
        dr_update();
        chk("R11 mode latch kept", {56'b0, mode_out}, 64'h5A);
        load_ir(3'b000, cap);
        chk("R11 boundary latch kept", {26'b0, pin_out}, {26'b0, BPAT});

        // R7: capture does not touch the mode shift stage
        load_ir(3'b011, cap);
        dr_capture();
        dr_shift(8, 64'd0, ov, oeall);
        chk("R7 no capture in mode reg", ov, 64'hFF);

        // R8 / R2: TAP reset keeps mode latch, restores id path
        tap_rst = 1; tick(); tap_rst = 0;
        chk("R8 mode kept over tap reset", {56'b0, mode_out}, 64'h5A);
        chk("R2 pins released after tap reset", {26'b0, pin_out}, {26'b0, CORE});
        dr_capture();
        dr_shift(32, 64'd0, ov, oeall);
        chk("R2 id path after tap reset", ov, {32'b0, ID_EXP});

        por = 1; tick(); por = 0; tick();
        chk("R8 por clears mode", {56'b0, mode_out}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule